// File: doc/BRIEF.md
# Translation Regime Configuration Decoder

This block sits at the front of a page-table walker and turns a virtual address plus a 32-bit translation control word into the setup a walk needs. It decides which of the two translation base registers covers the address: the low region, whose addresses have all-zero top bits, or the high region, whose addresses have all-one top bits. When neither covers the address it reports a translation fault.

For the chosen region it decodes the granule size into a per-level index stride and checks the region's walk-disable bit. It computes the first lookup level from the input-address width and the stride. It also clears the address bits above the region's input size. Reading descriptors, permission checks and TLB storage belong to other blocks.

The decode is combinational. A parameter selects whether the results pass through an output register, which gives one cycle of latency and a reset value. The default build has the register.

Top module: `xlat_regime_decoder`

## Requirements
- R1: With the output register present (default), every output is zero while `rst` is high. Results for inputs applied before a rising edge appear after that edge, one cycle of latency.
- R2: The low-region size field is `ctlWord[5:0]` and the high-region size field is `ctlWord[21:16]`. When `is64State` is 1, a field value below 16 is used as 16. When `is64State` is 0, a value above 31 is used as 31.
- R3: The address width is 64 when `is64State` is 1 and 32 otherwise. A region with a non-zero size S covers the address when the top S bits of that width are all zero (low region) or all one (high region). The low region is tested first. `regionSel` is 0 for low and 1 for high.
- R4: If neither region covers the address, the low region is chosen when its size is zero, and otherwise the high region is chosen when its size is zero. If both sizes are non-zero, `xlatFault` is 1, `regionSel` is 0 and `maskedAddr` is 0. In that case the stride and level describe the low region.
- R5: Bit 7 disables walks for the low region and bit 23 disables them for the high region. When the selected region's disable bit is 1, `xlatFault` is 1 and the other outputs still describe that region.
- R6: For the low region, `ctlWord[15:14]` gives `granStride`: 0 gives 9, 1 gives 13, 2 gives 11 and 3 gives 9.
- R7: For the high region, `ctlWord[31:30]` gives `granStride`: 1 gives 11, 3 gives 13, and any other value gives 9.
- R8: With N equal to the address width minus the selected size and s equal to the stride, `startLevel` is 0 if N > 4s+3. Otherwise it is 1 if N > 3s+3. Otherwise it is 2.
- R9: `maskedAddr` equals the address with every bit at position N and above cleared. When `is64State` is 0, `vaIn[63:32]` has no effect and `maskedAddr[63:32]` is 0.
- R10: Control bits 6, 8 to 13, 22 and 24 to 29 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| vaIn | input | 64 | Virtual address to classify |
| ctlWord | input | 32 | Translation control word |
| is64State | input | 1 | 1 selects 64-bit execution state |
| regionSel | output | 1 | 0 for the low region, 1 for the high region |
| granStride | output | 4 | Per-level index stride in bits (9, 11 or 13) |
| startLevel | output | 2 | First lookup level (0, 1 or 2) |
| maskedAddr | output | 64 | Address with bits above the input size cleared |
| xlatFault | output | 1 | Translation fault |

## Verification
The block holds no state beyond its output register, so any internal error appears at the ports one cycle after the input that triggers it. The fault can come from a wrong region choice, a size clamp applied to the wrong state, or a granule code read from the wrong field. It shows as a flipped `regionSel` or `xlatFault`, a stride outside the chosen region's encoding, or a level or mask boundary that is off by one. The sweep covers every pair of low and high size values in both execution states. This exercises each clamp edge and each level threshold.

// File: rtl/xlat_regime_pkg.sv
`timescale 1ns/1ps
package xlat_regime_pkg;

  // Width of a region size field and of an input-size value.
  localparam int SZ_W = 6;
  localparam int IN_W = SZ_W + 1;

  // Control word field positions (decoded by neighbours, so fixed).
  localparam int LO_SZ_LSB  = 0;
  localparam int HI_SZ_LSB  = 16;
  localparam int LO_OFF_BIT = 7;
  localparam int HI_OFF_BIT = 23;
  localparam int LO_GR_LSB  = 14;
  localparam int HI_GR_LSB  = 30;

  typedef enum logic [1:0] {
    GRAN_4K  = 2'd0,
    GRAN_16K = 2'd1,
    GRAN_64K = 2'd2
  } granule_e;

  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic            selHigh;
    logic            noMatch;
    logic            walkOff;
    logic [IN_W-1:0] inSize;
    granule_e        gran;
  } regimeStrobe_t;

  function automatic logic [3:0] strideOf(input granule_e g);
    case (g)
      GRAN_16K: return 4'd11;
      GRAN_64K: return 4'd13;
      default:  return 4'd9;
    endcase
  endfunction

  function automatic granule_e decodeLowGran(input logic [1:0] f);
    case (f)
      2'd1:    return GRAN_64K;
      2'd2:    return GRAN_16K;
      default: return GRAN_4K;
    endcase
  endfunction

  function automatic granule_e decodeHighGran(input logic [1:0] f);
    case (f)
      2'd1:    return GRAN_16K;
      2'd3:    return GRAN_64K;
      default: return GRAN_4K;
    endcase
  endfunction

endpackage

// File: rtl/xlat_regime_ctrl.sv
`timescale 1ns/1ps
module xlat_regime_ctrl
  import xlat_regime_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int NARROW_W = 32,
  parameter int MIN_SZ64 = 16
) (
  input  logic [ADDR_W-1:0] vaIn,
  input  logic [31:0]       ctlWord,
  input  logic              is64State,
  output regimeStrobe_t     strobe
);

  localparam int NREG = 2;

  function automatic logic [ADDR_W-1:0] lowMask(input logic [IN_W-1:0] n);
    if (int'(n) >= ADDR_W) return '1;
    return (ADDR_W'(1) << n) - ADDR_W'(1);
  endfunction

  function automatic logic [SZ_W-1:0] clampSize(input logic [SZ_W-1:0] raw,
                                                 input logic wide);
    if (wide && raw < SZ_W'(MIN_SZ64))       return SZ_W'(MIN_SZ64);
    if (!wide && raw > SZ_W'(NARROW_W - 1))  return SZ_W'(NARROW_W - 1);
    return raw;
  endfunction

  logic [IN_W-1:0]             vaWidth;
  logic [ADDR_W-1:0]           vaWin;
  logic [NREG-1:0][SZ_W-1:0]   szEff;
  logic [NREG-1:0]             topZero;
  logic [NREG-1:0]             topOnes;

  assign vaWidth = is64State ? IN_W'(ADDR_W) : IN_W'(NARROW_W);
  assign vaWin   = lowMask(vaWidth);

  // Identical top-bit test for each region.
  for (genvar r = 0; r < NREG; r++) begin : g_region
    localparam int FLD = (r == 0) ? LO_SZ_LSB : HI_SZ_LSB;
    logic [SZ_W-1:0]   szR;
    logic [ADDR_W-1:0] topMask;
    logic [ADDR_W-1:0] topBits;

    assign szR        = clampSize(ctlWord[FLD +: SZ_W], is64State);
    assign topMask    = vaWin & ~lowMask(vaWidth - IN_W'(szR));
    assign topBits    = vaIn & topMask;
    assign szEff[r]   = szR;
    assign topZero[r] = (szR != '0) && (topBits == '0);
    assign topOnes[r] = (szR != '0) && (topBits == topMask);
  end

  logic            selHigh;
  logic            noMatch;
  logic [SZ_W-1:0] selSize;

  always_comb begin
    selHigh = 1'b0;
    noMatch = 1'b0;
    if (topZero[0]) begin
      selHigh = 1'b0;
    end else if (topOnes[1]) begin
      selHigh = 1'b1;
    end else if (szEff[0] == '0) begin
      selHigh = 1'b0;
    end else if (szEff[1] == '0) begin
      selHigh = 1'b1;
    end else begin
      noMatch = 1'b1;
    end
  end

  assign selSize = selHigh ? szEff[1] : szEff[0];

  always_comb begin
    strobe.selHigh = selHigh;
    strobe.noMatch = noMatch;
    strobe.walkOff = selHigh ? ctlWord[HI_OFF_BIT] : ctlWord[LO_OFF_BIT];
    strobe.inSize  = vaWidth - IN_W'(selSize);
    strobe.gran    = selHigh ? decodeHighGran(ctlWord[HI_GR_LSB +: 2])
                             : decodeLowGran(ctlWord[LO_GR_LSB +: 2]);
  end

endmodule

// File: rtl/xlat_regime_dpath.sv
`timescale 1ns/1ps
module xlat_regime_dpath
  import xlat_regime_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int NARROW_W = 32,
  parameter bit REG_OUT  = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] vaIn,
  input  logic              is64State,
  input  regimeStrobe_t     strobe,
  output logic              regionSel,
  output logic [3:0]        granStride,
  output logic [1:0]        startLevel,
  output logic [ADDR_W-1:0] maskedAddr,
  output logic              xlatFault
);

  function automatic logic [ADDR_W-1:0] lowMask(input logic [IN_W-1:0] n);
    if (int'(n) >= ADDR_W) return '1;
    return (ADDR_W'(1) << n) - ADDR_W'(1);
  endfunction

  logic              nextSel;
  logic [3:0]        nextStride;
  logic [1:0]        nextLevel;
  logic [ADDR_W-1:0] nextMask;
  logic              nextFault;
  logic [IN_W-1:0]   strideW;
  logic [IN_W-1:0]   thrLevel0;
  logic [IN_W-1:0]   thrLevel1;
  logic [ADDR_W-1:0] vaEff;

  assign nextStride = strideOf(strobe.gran);
  assign strideW    = IN_W'(nextStride);
  assign thrLevel0  = (strideW << 2) + IN_W'(3);
  assign thrLevel1  = (strideW << 1) + strideW + IN_W'(3);

  always_comb begin
    if (strobe.inSize > thrLevel0)      nextLevel = 2'd0;
    else if (strobe.inSize > thrLevel1) nextLevel = 2'd1;
    else                                nextLevel = 2'd2;
  end

  assign vaEff     = is64State ? vaIn : (vaIn & lowMask(IN_W'(NARROW_W)));
  assign nextMask  = strobe.noMatch ? '0 : (vaEff & lowMask(strobe.inSize));
  assign nextSel   = strobe.selHigh;
  assign nextFault = strobe.noMatch | strobe.walkOff;

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        regionSel  <= 1'b0;
        granStride <= '0;
        startLevel <= '0;
        maskedAddr <= '0;
        xlatFault  <= 1'b0;
      end else begin
        regionSel  <= nextSel;
        granStride <= nextStride;
        startLevel <= nextLevel;
        maskedAddr <= nextMask;
        xlatFault  <= nextFault;
      end
    end
  end else begin : g_comb
    assign regionSel  = nextSel;
    assign granStride = nextStride;
    assign startLevel = nextLevel;
    assign maskedAddr = nextMask;
    assign xlatFault  = nextFault;
  end

endmodule

// File: rtl/xlat_regime_decoder.sv
`timescale 1ns/1ps
module xlat_regime_decoder
  import xlat_regime_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int NARROW_W = 32,
  parameter int MIN_SZ64 = 16,
  parameter bit REG_OUT  = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] vaIn,
  input  logic [31:0]       ctlWord,
  input  logic              is64State,
  output logic              regionSel,
  output logic [3:0]        granStride,
  output logic [1:0]        startLevel,
  output logic [ADDR_W-1:0] maskedAddr,
  output logic              xlatFault
);

  regimeStrobe_t strobe;

  xlat_regime_ctrl #(
    .ADDR_W   (ADDR_W),
    .NARROW_W (NARROW_W),
    .MIN_SZ64 (MIN_SZ64)
  ) u_ctrl (
    .vaIn      (vaIn),
    .ctlWord   (ctlWord),
    .is64State (is64State),
    .strobe    (strobe)
  );

  xlat_regime_dpath #(
    .ADDR_W   (ADDR_W),
    .NARROW_W (NARROW_W),
    .REG_OUT  (REG_OUT)
  ) u_dpath (
    .clk        (clk),
    .rst        (rst),
    .vaIn       (vaIn),
    .is64State  (is64State),
    .strobe     (strobe),
    .regionSel  (regionSel),
    .granStride (granStride),
    .startLevel (startLevel),
    .maskedAddr (maskedAddr),
    .xlatFault  (xlatFault)
  );

endmodule

// File: rtl/xlat_regime_checker.sv
`timescale 1ns/1ps
module xlat_regime_checker #(
  parameter int ADDR_W   = 64,
  parameter int NARROW_W = 32,
  parameter bit REG_OUT  = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] vaIn,
  input logic [31:0]       ctlWord,
  input logic              is64State,
  input logic              regionSel,
  input logic [3:0]        granStride,
  input logic [1:0]        startLevel,
  input logic [ADDR_W-1:0] maskedAddr,
  input logic              xlatFault
);

  // Inputs aligned with the outputs they produced.
  logic [ADDR_W-1:0] vaSeen;
  logic [31:0]       ctlSeen;
  logic              wideSeen;
  logic              armed;

  if (REG_OUT) begin : g_align
    always_ff @(posedge clk) begin
      vaSeen   <= vaIn;
      ctlSeen  <= ctlWord;
      wideSeen <= is64State;
    end
  end else begin : g_direct
    assign vaSeen   = vaIn;
    assign ctlSeen  = ctlWord;
    assign wideSeen = is64State;
  end

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  p_mask_subset_r9: assert property (@(posedge clk) disable iff (rst)
    armed |-> ((maskedAddr & ~vaSeen) == '0));

  p_narrow_upper_r9: assert property (@(posedge clk) disable iff (rst)
    (armed && !wideSeen) |-> (maskedAddr[ADDR_W-1:NARROW_W] == '0));

  p_low_off_fault_r5: assert property (@(posedge clk) disable iff (rst)
    (armed && !regionSel && ctlSeen[7]) |-> xlatFault);

  p_high_off_fault_r5: assert property (@(posedge clk) disable iff (rst)
    (armed && regionSel && ctlSeen[23]) |-> xlatFault);

  p_stride_legal_r6: assert property (@(posedge clk) disable iff (rst)
    armed |-> (granStride == 4'd9 || granStride == 4'd11 || granStride == 4'd13));

  p_level_legal_r8: assert property (@(posedge clk) disable iff (rst)
    armed |-> (startLevel != 2'd3));

endmodule

bind xlat_regime_decoder xlat_regime_checker #(
  .ADDR_W   (ADDR_W),
  .NARROW_W (NARROW_W),
  .REG_OUT  (REG_OUT)
) u_checker (
  .clk        (clk),
  .rst        (rst),
  .vaIn       (vaIn),
  .ctlWord    (ctlWord),
  .is64State  (is64State),
  .regionSel  (regionSel),
  .granStride (granStride),
  .startLevel (startLevel),
  .maskedAddr (maskedAddr),
  .xlatFault  (xlatFault)
);

// File: tb/xlat_regime_decoder_bench.sv
`timescale 1ns/1ps
module xlat_regime_decoder_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] vaIn = '0;
  logic [31:0] ctlWord = '0;
  logic        is64State = 1'b0;
  logic        regionSel;
  logic [3:0]  granStride;
  logic [1:0]  startLevel;
  logic [63:0] maskedAddr;
  logic        xlatFault;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic        eSel, eFault;
  logic [3:0]  eStride;
  logic [1:0]  eLvl;
  logic [63:0] eMask;

  always #2.5 clk = ~clk;

  xlat_regime_decoder u_xlat_regime_decoder (
    .clk(clk), .rst(rst), .vaIn(vaIn), .ctlWord(ctlWord), .is64State(is64State),
    .regionSel(regionSel), .granStride(granStride), .startLevel(startLevel),
    .maskedAddr(maskedAddr), .xlatFault(xlatFault)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Expected outputs from the requirement text.
  task automatic model(input logic [63:0] va, input logic [31:0] ctl, input logic w64);
    int vaw, lo, hi, sz, inS, s;
    logic [63:0] v;
    bit zLo, oHi, sH, nm;
    vaw = w64 ? 64 : 32;
    lo = int'(ctl[5:0]);
    hi = int'(ctl[21:16]);
    if (w64 && lo < 16) lo = 16;
    if (w64 && hi < 16) hi = 16;
    if (!w64 && lo > 31) lo = 31;
    if (!w64 && hi > 31) hi = 31;
    v = w64 ? va : {32'h0, va[31:0]};
    zLo = (lo != 0) && ((v >> (vaw - lo)) == 64'd0);
    oHi = (hi != 0) && ((v >> (vaw - hi)) == ((64'd1 << hi) - 64'd1));
    sH = 0; nm = 0;
    if (zLo) sH = 0;
    else if (oHi) sH = 1;
    else if (lo == 0) sH = 0;
    else if (hi == 0) sH = 1;
    else nm = 1;
    sz  = sH ? hi : lo;
    inS = vaw - sz;
    if (sH) s = (ctl[31:30] == 2'd1) ? 11 : (ctl[31:30] == 2'd3) ? 13 : 9;
    else    s = (ctl[15:14] == 2'd1) ? 13 : (ctl[15:14] == 2'd2) ? 11 : 9;
    eStride = 4'(s);
    eLvl    = (inS > 4*s + 3) ? 2'd0 : (inS > 3*s + 3) ? 2'd1 : 2'd2;
    eSel    = sH;
    eFault  = nm || (sH ? ctl[23] : ctl[7]);
    eMask   = nm ? 64'd0 : (inS >= 64 ? v : (v & ((64'd1 << inS) - 64'd1)));
  endtask

  // Drive at a falling edge; result sampled one rising edge later (R1).
  task automatic apply(input logic [63:0] va, input logic [31:0] ctl, input logic w64);
    @(negedge clk);
    vaIn = va; ctlWord = ctl; is64State = w64;
    @(negedge clk);
    model(va, ctl, w64);
  endtask

  task automatic compareAll();
    check("R3", "regionSel",  64'(regionSel),  64'(eSel));
    check("R5", "xlatFault",  64'(xlatFault),  64'(eFault));
    check("R6", "granStride", 64'(granStride), 64'(eStride));
    check("R8", "startLevel", 64'(startLevel), 64'(eLvl));
    check("R9", "maskedAddr", maskedAddr,      eMask);
  endtask

  function automatic logic [63:0] addrOf(input int kind);
    case (kind)
      0: return 64'h0000_0000_0000_1F3C;
      1: return 64'hFFFF_FFFF_FFFF_E0C4;
      2: return 64'hFFFF_0000_7FFF_1234;
      default: return 64'h8123_4567_89AB_CDEF;
    endcase
  endfunction

  function automatic logic [31:0] ctlOf(input int lo, input int hi, input int kind);
    logic [31:0] c;
    c = '0;
    c[5:0]   = 6'(lo);
    c[21:16] = 6'(hi);
    c[15:14] = 2'(lo) ^ 2'(kind);
    c[31:30] = 2'(hi >> 2);
    c[7]     = ((lo + hi + kind) % 7) == 0;
    c[23]    = ((3*lo + hi + kind) % 5) == 0;
    c[6]     = 1'(hi);
    c[13:8]  = 6'(lo ^ hi);
    c[22]    = 1'(kind);
    c[29:24] = 6'(hi) ^ 6'h2A;
    return c;
  endfunction

  localparam logic [31:0] IGN_BITS = 32'h3F40_3F40;

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset holds all outputs at zero.
    check("R1", "reset regionSel",  64'(regionSel),  64'd0);
    check("R1", "reset granStride", 64'(granStride), 64'd0);
    check("R1", "reset startLevel", 64'(startLevel), 64'd0);
    check("R1", "reset maskedAddr", maskedAddr,      64'd0);
    check("R1", "reset xlatFault",  64'(xlatFault),  64'd0);
    @(negedge clk);
    rst = 1'b0;

    // R1: one-cycle latency on a first vector.
    apply(64'h0000_1234_5678_9ABC, 32'h0010_0010, 1'b1);
    check("R1", "latency maskedAddr", maskedAddr, 64'h0000_1234_5678_9ABC);

    // R2: 64-bit size 5 is used as 16; 64K granule, N=48 gives level 1.
    apply(64'h0000_8000_0000_0000, 32'h0000_4005, 1'b1);
    check("R2", "clamp to 16 level", 64'(startLevel), 64'd1);
    check("R2", "clamp to 16 sel",   64'(regionSel),  64'd0);
    // R2: 32-bit size 40 is used as 31; N=1.
    apply(64'h0000_0000_0000_0001, 32'h0000_0028, 1'b0);
    check("R2", "clamp to 31 mask",  maskedAddr,      64'd1);
    check("R2", "clamp to 31 fault", 64'(xlatFault),  64'd0);

    // R8: thresholds with the 4K granule.
    apply(64'h0, 32'h0000_0018, 1'b1);
    check("R8", "N=40 level", 64'(startLevel), 64'd0);
    apply(64'h0, 32'h0000_0019, 1'b1);
    check("R8", "N=39 level", 64'(startLevel), 64'd1);
    apply(64'h0, 32'h0000_0022, 1'b1);
    check("R8", "N=30 level", 64'(startLevel), 64'd2);

    // R4: both sizes non-zero and no match.
    apply(64'h0000_0000_5000_0000, 32'h0008_0008, 1'b0);
    check("R4", "no match fault", 64'(xlatFault), 64'd1);
    check("R4", "no match mask",  maskedAddr,     64'd0);
    // R4: low size non-zero, high size zero, falls back to high.
    apply(64'h0000_0000_F000_0000, 32'h0000_0004, 1'b0);
    check("R4", "fallback sel",  64'(regionSel), 64'd1);
    check("R4", "fallback mask", maskedAddr,     64'h0000_0000_F000_0000);

    // R5 and R7: high region disabled, 16K code 1, N=48 gives level 0.
    apply(64'hFFFF_0000_0000_0042, 32'h4090_0010, 1'b1);
    check("R5", "high off fault", 64'(xlatFault),  64'd1);
    check("R5", "high off sel",   64'(regionSel),  64'd1);
    check("R7", "high 16K stride", 64'(granStride), 64'd11);
    check("R8", "high 16K level",  64'(startLevel), 64'd0);

    // R9: upper address half ignored in 32-bit state.
    apply(64'hDEAD_BEEF_0000_0ABC, 32'h0000_0000, 1'b0);
    check("R9", "narrow mask", maskedAddr, 64'h0000_0000_0000_0ABC);

    // R10: flipping unused control bits leaves outputs unchanged.
    for (int k = 0; k < 4; k++) begin
      logic [31:0] base;
      logic [63:0] m0;
      logic [3:0]  s0;
      logic [1:0]  l0;
      logic        f0, r0;
      base = ctlOf(17 + 3*k, 20 + k, k);
      apply(addrOf(k), base, 1'(k));
      m0 = maskedAddr; s0 = granStride; l0 = startLevel; f0 = xlatFault; r0 = regionSel;
      apply(addrOf(k), base ^ IGN_BITS, 1'(k));
      check("R10", "ignored bits mask",   maskedAddr,      m0);
      check("R10", "ignored bits stride", 64'(granStride), 64'(s0));
      check("R10", "ignored bits level",  64'(startLevel), 64'(l0));
      check("R10", "ignored bits fault",  64'(xlatFault),  64'(f0));
      check("R10", "ignored bits sel",    64'(regionSel),  64'(r0));
    end

    // Sweep: all size pairs, both states, four address shapes (R2-R9).
    for (int w = 0; w < 2; w++) begin
      for (int lo = 0; lo < 64; lo++) begin
        for (int hi = 0; hi < 64; hi++) begin
          for (int kind = 0; kind < 4; kind++) begin
            apply(addrOf(kind), ctlOf(lo, hi, kind), 1'(w));
            compareAll();
          end
        end
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule